// File: doc/BRIEF.md
# Indexed Processor Configuration Register Bank

This block exposes a bank of 8-bit processor configuration registers through a pair of byte ports. A write to the even port (`bus_odd` low) stores the data byte as the current index. A read or write on the odd port (`bus_odd` high) then reaches the register that the index selects. The bank holds control bytes, a table of address-region bytes and a set of region-control bytes. Read data is presented combinationally for the currently latched index.

Access to each register is gated by four things: a sticky lock bit, an input that says the processor is in system-management mode, a map-enable nibble and a region-enable bit. A locked write outside system-management mode keeps certain protected bits at their old values. From three of the region bytes the block decodes the base and size of the system-management memory window. It also gives a one-cycle pulse whenever a write lands on one of those three bytes, and another one-cycle pulse whenever the memory-access control bit changes.

Top module: `cfgp_bank`

## Requirements
- R1: A write with `bus_odd`=0 stores `bus_wdata` as the index. Writes with `bus_odd`=1 update the indexed register. `rd_data` shows the indexed register. Control bytes 0xC0, 0xC2 and the scratch byte 0x30 are always readable and writable.
- R2: When lock bit 0 of control byte 0xC3 is 1 and `smm_active` is 0, a write to 0xC1 keeps bits 7, 2 and 1 at their old values and takes the other bits from the data.
- R3: Under the same locked, non-SMM condition, a write to 0xC3 keeps the old bit 1 and forces bit 0 to 1. In SMM the write is taken in full.
- R4: Bytes 0xE8–0xEA and the region-control bytes 0xDC–0xE3 can be accessed only while bits 7:4 of 0xC3 equal 0x1. Otherwise a read returns 0xFF and a write is ignored.
- R5: A write to 0xEB keeps only data bits 0 and 2. The other bits read as 0.
- R6: Region bytes 0xC4–0xCC can be accessed only while bit 5 of 0xE9 is 1 (blocked read 0xFF, blocked write ignored).
- R7: Region bytes 0xD0–0xDB need bit 5 of 0xE9 to be 1 and bits 7:4 of 0xC3 to equal 0x1.
- R8: Region bytes 0xCD–0xCF can be accessed when bit 5 of 0xE9 is 1, or the lock is clear, or `smm_active` is 1. Each accepted write to them pulses `hdr_inval` high for the one cycle after the write edge.
- R9: `smm_base` equals {byte 0xCD, byte 0xCE, bits 7:4 of byte 0xCF, 12'h000}.
- R10: `smm_size` is 0 when bits 3:0 of 0xCF are 0, 2^32 when they are 0xF, and 2048 shifted left by n for any other value n.
- R11: After reset, 0xE8 holds 0x80, 0x30 holds 0xFF, and every other control, region and region-control byte holds 0x00.
- R12: A write that changes bit 2 of 0xC1 pulses `smac_chg` high for the one cycle after the write edge. `smac_val` always shows bit 2 of 0xC1. A write that leaves the bit unchanged gives no pulse.
- R13: A read of an unimplemented index returns 0xFF. Indexes 0xFE and 0xFF return the fixed identification bytes `DEV_ID_LO` and `DEV_ID_HI`, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_odd | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| smm_active | input | 1 | Processor is in system-management mode |
| rd_data | output | 8 | Read value of the indexed register |
| smm_base | output | 32 | Decoded SMM window base address |
| smm_size | output | 33 | Decoded SMM window size in bytes (0 = disabled) |
| hdr_inval | output | 1 | One-cycle pulse after a write to the SMM window bytes |
| smac_chg | output | 1 | One-cycle pulse after bit 2 of 0xC1 changes |
| smac_val | output | 1 | Current value of bit 2 of 0xC1 |

## Verification
Access gating is exercised with each combination that changes the outcome: lock clear or set, SMM high or low, map nibble matching or not, region enable on or off. After each blocked write, the same byte is read back once the gate is open again. This separates a write that was ignored from a read that was only masked. Locked writes with all-ones and with mixed data show whether protected bits are kept or forced. Window sizes 0, 0xF and a middle value cover the three branches of the size decode. Writes to 0xC1 that toggle bit 2 and writes that leave it alone show whether the change pulse follows the bit or the write strobe.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int BYTE_W   = 8;
    localparam int WIN_AW   = 32;
    localparam int SIZE_W   = WIN_AW + 1;

    localparam logic [7:0] IX_SCRATCH = 8'h30;
    localparam logic [7:0] IX_CTL0    = 8'hC0;
    localparam logic [7:0] IX_CTL1    = 8'hC1;
    localparam logic [7:0] IX_CTL2    = 8'hC2;
    localparam logic [7:0] IX_CTL3    = 8'hC3;
    localparam logic [7:0] IX_RGN_LO  = 8'hC4;
    localparam logic [7:0] IX_WIN_HI  = 8'hCD;
    localparam logic [7:0] IX_WIN_LO  = 8'hCF;
    localparam logic [7:0] IX_RGN_MID = 8'hD0;
    localparam logic [7:0] IX_RGN_TOP = 8'hDB;
    localparam logic [7:0] IX_RCT_LO  = 8'hDC;
    localparam logic [7:0] IX_RCT_HI  = 8'hE3;
    localparam logic [7:0] IX_CTL4    = 8'hE8;
    localparam logic [7:0] IX_CTL5    = 8'hE9;
    localparam logic [7:0] IX_CTL6    = 8'hEA;
    localparam logic [7:0] IX_CTL7    = 8'hEB;
    localparam logic [7:0] IX_ID_LO   = 8'hFE;
    localparam logic [7:0] IX_ID_HI   = 8'hFF;

    localparam logic [7:0] C1_KEEP    = 8'h86;
    localparam logic [7:0] C7_MASK    = 8'h05;
    localparam logic [3:0] MAP_KEY    = 4'h1;
    localparam int         C1_SMAC    = 2;
    localparam int         C5_RGN_EN  = 5;
    localparam logic [7:0] BLOCK_VAL  = 8'hFF;

    typedef enum logic [3:0] {
        RC_NONE,
        RC_SCRATCH,
        RC_PLAIN,
        RC_CTL1,
        RC_CTL3,
        RC_RGN_BASIC,
        RC_RGN_WIN,
        RC_RGN_MAPPED,
        RC_RCTL,
        RC_MAPPED,
        RC_CTL7,
        RC_ID
    } reg_class_e;

    typedef struct packed {
        logic locked;
        logic in_smm;
        logic map_on;
        logic rgn_on;
    } gate_ctx_t;

    function automatic reg_class_e classify(input logic [7:0] ix);
        reg_class_e c;
        c = RC_NONE;
        if (ix == IX_SCRATCH)                            c = RC_SCRATCH;
        else if (ix == IX_CTL0 || ix == IX_CTL2)         c = RC_PLAIN;
        else if (ix == IX_CTL1)                          c = RC_CTL1;
        else if (ix == IX_CTL3)                          c = RC_CTL3;
        else if (ix >= IX_RGN_LO && ix < IX_WIN_HI)      c = RC_RGN_BASIC;
        else if (ix >= IX_WIN_HI && ix <= IX_WIN_LO)     c = RC_RGN_WIN;
        else if (ix >= IX_RGN_MID && ix <= IX_RGN_TOP)   c = RC_RGN_MAPPED;
        else if (ix >= IX_RCT_LO && ix <= IX_RCT_HI)     c = RC_RCTL;
        else if (ix >= IX_CTL4 && ix <= IX_CTL6)         c = RC_MAPPED;
        else if (ix == IX_CTL7)                          c = RC_CTL7;
        else if (ix == IX_ID_LO || ix == IX_ID_HI)       c = RC_ID;
        return c;
    endfunction

    function automatic logic [SIZE_W-1:0] win_size(input logic [3:0] code);
        logic [SIZE_W-1:0] s;
        if (code == 4'h0)      s = '0;
        else if (code == 4'hF) s = {1'b1, {WIN_AW{1'b0}}};
        else                   s = SIZE_W'(2048) << code;
        return s;
    endfunction

endpackage

// File: rtl/cfgp_index_reg.sv
module cfgp_index_reg
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] ix
);
    always_ff @(posedge clk) begin
        if (rst)       ix <= '0;
        else if (load) ix <= din;
    end
endmodule

// File: rtl/cfgp_gate.sv
module cfgp_gate
    import cfgp_pkg::*;
(
    input  reg_class_e cls,
    input  gate_ctx_t  ctx,
    output logic       rd_ok,
    output logic       wr_ok
);
    logic win_open;
    assign win_open = ctx.rgn_on || !ctx.locked || ctx.in_smm;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (cls)
            RC_SCRATCH, RC_PLAIN, RC_CTL1, RC_CTL3, RC_CTL7: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            RC_RGN_BASIC: begin
                rd_ok = ctx.rgn_on;
                wr_ok = ctx.rgn_on;
            end
            RC_RGN_WIN: begin
                rd_ok = win_open;
                wr_ok = win_open;
            end
            RC_RGN_MAPPED: begin
                rd_ok = ctx.rgn_on && ctx.map_on;
                wr_ok = ctx.rgn_on && ctx.map_on;
            end
            RC_RCTL, RC_MAPPED: begin
                rd_ok = ctx.map_on;
                wr_ok = ctx.map_on;
            end
            RC_ID: begin
                rd_ok = 1'b1;
                wr_ok = 1'b0;
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfgp_smm_window.sv
module cfgp_smm_window
    import cfgp_pkg::*;
(
    input  logic [BYTE_W-1:0] b_hi,
    input  logic [BYTE_W-1:0] b_mid,
    input  logic [BYTE_W-1:0] b_lo,
    output logic [WIN_AW-1:0] base,
    output logic [SIZE_W-1:0] size
);
    localparam int LOW_ZERO = WIN_AW - 2*BYTE_W - 4;

    assign base = {b_hi, b_mid, b_lo[7:4], {LOW_ZERO{1'b0}}};
    assign size = win_size(b_lo[3:0]);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
    import cfgp_pkg::*;
#(
    parameter int          NUM_RGN   = 24,
    parameter int          NUM_RCTL  = 8,
    parameter logic [7:0]  DEV_ID_LO = 8'h51,
    parameter logic [7:0]  DEV_ID_HI = 8'h17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_odd,
    input  logic [7:0]        bus_wdata,
    input  logic              smm_active,
    output logic [7:0]        rd_data,
    output logic [31:0]       smm_base,
    output logic [32:0]       smm_size,
    output logic              hdr_inval,
    output logic              smac_chg,
    output logic              smac_val
);
    localparam int RGN_OW  = $clog2(NUM_RGN);
    localparam int RCTL_OW = $clog2(NUM_RCTL);
    localparam int WIN_OFF = int'(IX_WIN_HI - IX_RGN_LO);

    logic [BYTE_W-1:0] ix_q;
    logic              ix_load, dat_wr;

    assign ix_load = bus_wr && !bus_odd;
    assign dat_wr  = bus_wr &&  bus_odd;

    cfgp_index_reg u_ix (
        .clk (clk),
        .rst (rst),
        .load(ix_load),
        .din (bus_wdata),
        .ix  (ix_q)
    );

    logic [7:0] scr_q, ctl0_q, ctl1_q, ctl2_q, ctl3_q;
    logic [7:0] ctl4_q, ctl5_q, ctl6_q;
    logic [1:0] ctl7_q;
    logic [NUM_RGN-1:0][7:0]  rgn_q;
    logic [NUM_RCTL-1:0][7:0] rct_q;
    logic hdr_q, smac_q;

    reg_class_e cls;
    gate_ctx_t  ctx;
    logic       rd_ok, wr_ok;
    logic [7:0] rgn_diff, rct_diff;
    logic [RGN_OW-1:0]  rgn_off;
    logic [RCTL_OW-1:0] rct_off;

    assign cls        = classify(ix_q);
    assign ctx.locked = ctl3_q[0];
    assign ctx.in_smm = smm_active;
    assign ctx.map_on = (ctl3_q[7:4] == MAP_KEY);
    assign ctx.rgn_on = ctl5_q[C5_RGN_EN];
    assign rgn_diff   = ix_q - IX_RGN_LO;
    assign rct_diff   = ix_q - IX_RCT_LO;
    assign rgn_off    = rgn_diff[RGN_OW-1:0];
    assign rct_off    = rct_diff[RCTL_OW-1:0];

    cfgp_gate u_gate (
        .cls  (cls),
        .ctx  (ctx),
        .rd_ok(rd_ok),
        .wr_ok(wr_ok)
    );

    logic       do_wr, guard;
    logic [7:0] ctl1_nx, ctl3_nx;

    assign do_wr = dat_wr && wr_ok;
    assign guard = ctx.locked && !smm_active;

    always_comb begin
        ctl1_nx = bus_wdata;
        ctl3_nx = bus_wdata;
        if (guard) begin
            ctl1_nx = (bus_wdata & ~C1_KEEP) | (ctl1_q & C1_KEEP);
            ctl3_nx = {bus_wdata[7:2], ctl3_q[1], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q  <= 8'hFF;
            ctl0_q <= '0;
            ctl1_q <= '0;
            ctl2_q <= '0;
            ctl3_q <= '0;
            ctl4_q <= 8'h80;
            ctl5_q <= '0;
            ctl6_q <= '0;
            ctl7_q <= '0;
            rgn_q  <= '0;
            rct_q  <= '0;
            hdr_q  <= 1'b0;
            smac_q <= 1'b0;
        end else begin
            hdr_q  <= do_wr && (cls == RC_RGN_WIN);
            smac_q <= do_wr && (cls == RC_CTL1) && (ctl1_nx[C1_SMAC] != ctl1_q[C1_SMAC]);
            if (do_wr) begin
                unique case (cls)
                    RC_SCRATCH: scr_q <= bus_wdata;
                    RC_PLAIN: begin
                        if (ix_q == IX_CTL0) ctl0_q <= bus_wdata;
                        else                 ctl2_q <= bus_wdata;
                    end
                    RC_CTL1: ctl1_q <= ctl1_nx;
                    RC_CTL3: ctl3_q <= ctl3_nx;
                    RC_RGN_BASIC, RC_RGN_WIN, RC_RGN_MAPPED:
                        rgn_q[rgn_off] <= bus_wdata;
                    RC_RCTL: rct_q[rct_off] <= bus_wdata;
                    RC_MAPPED: begin
                        if (ix_q == IX_CTL4)      ctl4_q <= bus_wdata;
                        else if (ix_q == IX_CTL5) ctl5_q <= bus_wdata;
                        else                      ctl6_q <= bus_wdata;
                    end
                    RC_CTL7: ctl7_q <= {bus_wdata[2], bus_wdata[0]};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = BLOCK_VAL;
        if (rd_ok) begin
            unique case (cls)
                RC_SCRATCH: rd_data = scr_q;
                RC_PLAIN:   rd_data = (ix_q == IX_CTL0) ? ctl0_q : ctl2_q;
                RC_CTL1:    rd_data = ctl1_q;
                RC_CTL3:    rd_data = ctl3_q;
                RC_RGN_BASIC, RC_RGN_WIN, RC_RGN_MAPPED:
                            rd_data = rgn_q[rgn_off];
                RC_RCTL:    rd_data = rct_q[rct_off];
                RC_MAPPED: begin
                    if (ix_q == IX_CTL4)      rd_data = ctl4_q;
                    else if (ix_q == IX_CTL5) rd_data = ctl5_q;
                    else                      rd_data = ctl6_q;
                end
                RC_CTL7:    rd_data = {5'b0, ctl7_q[1], 1'b0, ctl7_q[0]};
                RC_ID:      rd_data = (ix_q == IX_ID_LO) ? DEV_ID_LO : DEV_ID_HI;
                default:    rd_data = BLOCK_VAL;
            endcase
        end
    end

    cfgp_smm_window u_win (
        .b_hi (rgn_q[WIN_OFF]),
        .b_mid(rgn_q[WIN_OFF+1]),
        .b_lo (rgn_q[WIN_OFF+2]),
        .base (smm_base),
        .size (smm_size)
    );

    assign hdr_inval = hdr_q;
    assign smac_chg  = smac_q;
    assign smac_val  = ctl1_q[C1_SMAC];

    // R2
    c1_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && ix_q == IX_CTL1 && ctl3_q[0] && !smm_active)
        |=> ((ctl1_q & C1_KEEP) == ($past(ctl1_q) & C1_KEEP)));

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl3_q[0] && !smm_active) |=> ctl3_q[0]);

    // R4
    rctl_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && cls == RC_RCTL && ctl3_q[7:4] != MAP_KEY) |=> $stable(rct_q));

    // R8
    hdr_src_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_inval |-> $past(dat_wr));

    // R12
    smac_edge_chk: assert property (@(posedge clk) disable iff (rst)
        smac_chg |-> (smac_val != $past(smac_val)));

endmodule

// File: tb/cfgp_bank_test.sv
module cfgp_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_odd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        smm_active = 1'b0;
    logic [7:0]  rd_data;
    logic [31:0] smm_base;
    logic [32:0] smm_size;
    logic        hdr_inval, smac_chg, smac_val;

    int n_chk = 0;
    int n_fail = 0;
    logic got_hdr, got_smac;
    bit done = 0;

    always #10 clk = ~clk;

    cfgp_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_odd(bus_odd),
        .bus_wdata(bus_wdata), .smm_active(smm_active), .rd_data(rd_data),
        .smm_base(smm_base), .smm_size(smm_size), .hdr_inval(hdr_inval),
        .smac_chg(smac_chg), .smac_val(smac_val)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic odd, input logic [7:0] v);
        @(negedge clk);
        bus_odd = odd; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        got_hdr = hdr_inval;
        got_smac = smac_chg;
    endtask

    task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
        put(1'b0, ix);
        put(1'b1, v);
    endtask

    task automatic rchk(input string tag, input logic [7:0] ix, input logic [7:0] exp);
        put(1'b0, ix);
        #1 check(tag, {25'b0, rd_data}, {25'b0, exp});
    endtask

    task automatic t_reset;
        rchk("R11 scratch", 8'h30, 8'hFF);
        rchk("R11 ctl0", 8'hC0, 8'h00);
        rchk("R11 ctl3", 8'hC3, 8'h00);
        rchk("R11 win byte", 8'hCD, 8'h00);
        check("R11 size", smm_size, 33'h0);
        check("R11 base", {1'b0, smm_base}, 33'h0);
        wreg(8'hC3, 8'h10);
        rchk("R11 ctl4", 8'hE8, 8'h80);
        rchk("R11 rctl", 8'hE0, 8'h00);
        wreg(8'hC3, 8'h00);
    endtask

    task automatic t_plain;
        wreg(8'hC0, 8'h5A);
        rchk("R1 ctl0", 8'hC0, 8'h5A);
        wreg(8'hC2, 8'hA5);
        rchk("R1 ctl2", 8'hC2, 8'hA5);
        wreg(8'h30, 8'h3C);
        rchk("R1 scratch", 8'h30, 8'h3C);
    endtask

    task automatic t_mapped;
        wreg(8'hE9, 8'h20);
        rchk("R4 blocked read", 8'hE9, 8'hFF);
        wreg(8'hC3, 8'h10);
        rchk("R4 blocked write ignored", 8'hE9, 8'h00);
        wreg(8'hDC, 8'h33);
        rchk("R4 rctl write", 8'hDC, 8'h33);
        wreg(8'hC3, 8'h00);
        rchk("R4 rctl blocked read", 8'hDC, 8'hFF);
        wreg(8'hDC, 8'h44);
        wreg(8'hC3, 8'h10);
        rchk("R4 rctl write ignored", 8'hDC, 8'h33);
        wreg(8'hC3, 8'h00);
    endtask

    task automatic t_ctl7;
        wreg(8'hEB, 8'hFF);
        rchk("R5 mask ff", 8'hEB, 8'h05);
        wreg(8'hEB, 8'hFA);
        rchk("R5 mask fa", 8'hEB, 8'h00);
    endtask

    task automatic t_regions;
        wreg(8'hC4, 8'h11);
        rchk("R6 blocked read", 8'hC4, 8'hFF);
        wreg(8'hC3, 8'h10);
        wreg(8'hE9, 8'h20);
        rchk("R6 write ignored", 8'hC4, 8'h00);
        wreg(8'hC4, 8'h11);
        rchk("R6 enabled", 8'hC4, 8'h11);
        wreg(8'hD0, 8'h22);
        rchk("R7 enabled", 8'hD0, 8'h22);
        wreg(8'hC3, 8'h00);
        rchk("R7 map off read", 8'hD0, 8'hFF);
        wreg(8'hD0, 8'h99);
        rchk("R6 map independent", 8'hC4, 8'h11);
        wreg(8'hC3, 8'h10);
        rchk("R7 write ignored", 8'hD0, 8'h22);
        wreg(8'hC3, 8'h00);
    endtask

    task automatic t_window;
        wreg(8'hCD, 8'h12);
        check("R8 hdr pulse", {32'b0, got_hdr}, 33'h1);
        wreg(8'hCE, 8'h34);
        wreg(8'hCF, 8'h5A);
        check("R9 base", {1'b0, smm_base}, 33'h12345000);
        check("R10 size mid", smm_size, 33'h200000);
        wreg(8'hCF, 8'h5F);
        check("R10 size 4g", smm_size, 33'h1_0000_0000);
        wreg(8'hCF, 8'h50);
        check("R10 size off", smm_size, 33'h0);
        wreg(8'hC3, 8'h10);
        wreg(8'hE9, 8'h00);
        wreg(8'hC3, 8'h00);
        wreg(8'hCD, 8'hAB);
        rchk("R8 unlocked access", 8'hCD, 8'hAB);
        wreg(8'hC3, 8'h01);
        wreg(8'hCD, 8'h66);
        check("R8 no pulse when blocked", {32'b0, got_hdr}, 33'h0);
        rchk("R8 locked read", 8'hCD, 8'hFF);
        check("R9 base kept", {1'b0, smm_base}, 33'hAB345000);
        smm_active = 1'b1;
        wreg(8'hCD, 8'h77);
        check("R8 smm pulse", {32'b0, got_hdr}, 33'h1);
        check("R9 base smm", {1'b0, smm_base}, 33'h77345000);
        smm_active = 1'b0;
    endtask

    task automatic t_lock;
        smm_active = 1'b1;
        wreg(8'hC1, 8'h86);
        check("R12 pulse on rise", {32'b0, got_smac}, 33'h1);
        check("R12 value", {32'b0, smac_val}, 33'h1);
        smm_active = 1'b0;
        wreg(8'hC1, 8'h79);
        rchk("R2 protected kept", 8'hC1, 8'hFF);
        wreg(8'hC1, 8'h00);
        rchk("R2 protected kept zero data", 8'hC1, 8'h86);
        check("R12 value held", {32'b0, smac_val}, 33'h1);
        smm_active = 1'b1;
        wreg(8'hC3, 8'h03);
        smm_active = 1'b0;
        wreg(8'hC3, 8'h10);
        rchk("R3 lock forced nmi kept", 8'hC3, 8'h13);
        wreg(8'hC3, 8'h00);
        rchk("R3 cannot unlock", 8'hC3, 8'h03);
        smm_active = 1'b1;
        wreg(8'hC3, 8'h00);
        smm_active = 1'b0;
        rchk("R3 smm unlock", 8'hC3, 8'h00);
    endtask

    task automatic t_smac;
        wreg(8'hC1, 8'h00);
        check("R12 pulse on fall", {32'b0, got_smac}, 33'h1);
        check("R12 value low", {32'b0, smac_val}, 33'h0);
        wreg(8'hC1, 8'h01);
        check("R12 no pulse", {32'b0, got_smac}, 33'h0);
        wreg(8'hC1, 8'h04);
        check("R12 pulse again", {32'b0, got_smac}, 33'h1);
        put(1'b0, 8'hC0);
        check("R12 pulse one cycle", {32'b0, smac_chg}, 33'h0);
    endtask

    task automatic t_misc;
        rchk("R13 unimplemented", 8'h50, 8'hFF);
        wreg(8'hFE, 8'h00);
        rchk("R13 id low", 8'hFE, 8'h51);
        rchk("R13 id high", 8'hFF, 8'h17);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_mapped();
        t_ctl7();
        t_regions();
        t_window();
        t_lock();
        t_smac();
        t_misc();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule